// File: doc/BRIEF.md
# YCbCr Picture Adjustment Pipeline

This block adjusts a 4:4:4 YCbCr pixel stream, one pixel for each accepted transfer, before it goes to a display or encoder path. It applies three kinds of adjustment. A signed brightness offset is added to luma. A separate offset is added to each chroma channel to shift the hue. A saturation gain is applied to the Cr channel around the chroma midpoint. Every result is clamped to the legal sample range. The pixel reaches the output stream two cycles after it was accepted.

Four 8-bit settings are loaded through a plain write strobe with an address and a data byte. A setting that is written takes effect on the first pixel accepted after the write edge. Both the input and the output stream use valid/ready. The two pipeline stages advance together whenever the output register is empty or is being drained, and the input ready follows that same condition. When `m_valid` is high and `m_ready` is low, the whole pipeline freezes: the output holds its data, `s_ready` is low, and no input pixel is taken. When `m_ready` stays high, the block accepts one pixel on every cycle.

Top module: `yuv_proc_amp`

## Requirements
- R1: After reset, `m_valid` is 0 and `s_ready` is 1. The settings reset to neutral values: Cr gain 0x80, Cb offset 0x80, Cr offset 0x80 and brightness 0x00. With neutral settings each output pixel equals its input pixel.
- R2: The write addresses are 0x0A for brightness, 0xE1 for Cb offset, 0xE2 for Cr offset and 0xE4 for Cr gain. A write to any other address changes no setting.
- R3: The brightness code is read as 8-bit two's complement (0x7F is +127, 0x80 is -128) and added to Y only. Cb and Cr are not affected.
- R4: Each chroma offset code adds (code - 128) to its own channel only. So 0x00 gives -128 and 0xFF gives +127.
- R5: The Cr result is 128 + trunc((Cr - 128) * gain / 128) + (Cr offset code - 128), where trunc rounds toward zero. A gain of 0x00 gives a constant 128 before the offset.
- R6: Every output sample is clamped to the range 0 to 255.
- R7: When the output is not stalled, a pixel accepted at the clock edge that ends cycle c appears with `m_valid` high in cycle c+2. Back-to-back input gives back-to-back output.
- R8: While `m_valid` is 1 and `m_ready` is 0, `s_ready` is 0 and `m_y`, `m_cb` and `m_cr` hold their values.
- R9: A pixel accepted on the same edge as a setting write is processed with the old setting. Pixels accepted on later edges use the new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 8 | Setting write address |
| cfg_wdata | input | 8 | Setting write data |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted when high together with s_valid |
| s_y | input | 8 | Input luma |
| s_cb | input | 8 | Input Cb |
| s_cr | input | 8 | Input Cr |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream ready |
| m_y | output | 8 | Output luma |
| m_cb | output | 8 | Output Cb |
| m_cr | output | 8 | Output Cr |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge at start-up. They also assume that `m_ready` and `cfg_we` are known values on every edge, while `m_ready` itself may drop on any cycle, even with a pixel waiting. The stimulus drives every input on the falling edge only and keeps all inputs at defined values from time zero. It drops `m_ready` only in the scenario that tests stalls, and it writes settings while the pipeline is either idle or in the specific cycle chosen to test when a write takes effect.

// File: rtl/yuv_pa_pkg.sv
package yuv_pa_pkg;

  localparam int CODE_W = 8;

  localparam logic [CODE_W-1:0] ADDR_BRIGHT  = 8'h0A;
  localparam logic [CODE_W-1:0] ADDR_CB_OFF  = 8'hE1;
  localparam logic [CODE_W-1:0] ADDR_CR_OFF  = 8'hE2;
  localparam logic [CODE_W-1:0] ADDR_CR_GAIN = 8'hE4;

  localparam logic [CODE_W-1:0] RST_GAIN   = 8'h80;
  localparam logic [CODE_W-1:0] RST_OFF    = 8'h80;
  localparam logic [CODE_W-1:0] RST_BRIGHT = 8'h00;

  localparam int NCH  = 3;
  localparam int CH_Y  = 0;
  localparam int CH_CB = 1;
  localparam int CH_CR = 2;

  typedef struct packed {
    logic [CODE_W-1:0] cr_gain;
    logic [CODE_W-1:0] cb_off;
    logic [CODE_W-1:0] cr_off;
    logic [CODE_W-1:0] bright;
  } pa_cfg_t;

endpackage

// File: rtl/yuv_pa_regs.sv
module yuv_pa_regs
  import yuv_pa_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CODE_W-1:0] wdata,
  output pa_cfg_t           cfg
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.cr_gain <= RST_GAIN;
      cfg.cb_off  <= RST_OFF;
      cfg.cr_off  <= RST_OFF;
      cfg.bright  <= RST_BRIGHT;
    end else if (we) begin
      if (addr == ADDR_W'(ADDR_CR_GAIN)) cfg.cr_gain <= wdata;
      if (addr == ADDR_W'(ADDR_CB_OFF))  cfg.cb_off  <= wdata;
      if (addr == ADDR_W'(ADDR_CR_OFF))  cfg.cr_off  <= wdata;
      if (addr == ADDR_W'(ADDR_BRIGHT))  cfg.bright  <= wdata;
    end
  end

endmodule

// File: rtl/yuv_pa_gain.sv
module yuv_pa_gain #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 8,
  parameter int IW     = DATA_W + 3
) (
  input  logic [DATA_W-1:0]    px,
  input  logic [CODE_W-1:0]    gain,
  output logic signed [IW-1:0] res
);

  localparam int PW    = DATA_W + CODE_W + 2;
  localparam int SHIFT = CODE_W - 1;
  localparam logic signed [PW-1:0] MID_W  = PW'(1 << (DATA_W - 1));
  localparam logic signed [PW-1:0] BIAS_W = PW'((1 << SHIFT) - 1);

  logic signed [PW-1:0] diff, prod, quo, sum;

  always_comb begin
    diff = $signed({{(PW-DATA_W){1'b0}}, px}) - MID_W;
    prod = diff * $signed({{(PW-CODE_W){1'b0}}, gain});
    // negative products get a bias so the shift truncates toward zero
    quo  = (prod + (prod[PW-1] ? BIAS_W : '0)) >>> SHIFT;
    sum  = quo + MID_W;
    res  = sum[IW-1:0];
  end

endmodule

// File: rtl/yuv_pa_sat.sv
module yuv_pa_sat #(
  parameter int DATA_W = 8,
  parameter int IW     = DATA_W + 3
) (
  input  logic signed [IW-1:0] v,
  output logic [DATA_W-1:0]    o
);

  localparam logic signed [IW-1:0] TOP = IW'((1 << DATA_W) - 1);

  always_comb begin
    if (v[IW-1])      o = '0;
    else if (v > TOP) o = '1;
    else              o = v[DATA_W-1:0];
  end

endmodule

// File: rtl/yuv_proc_amp.sv
module yuv_proc_amp
  import yuv_pa_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_y,
  input  logic [DATA_W-1:0] s_cb,
  input  logic [DATA_W-1:0] s_cr,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_y,
  output logic [DATA_W-1:0] m_cb,
  output logic [DATA_W-1:0] m_cr
);

  localparam int IW = DATA_W + 3;

  pa_cfg_t cfg_q;

  yuv_pa_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .cfg   (cfg_q)
  );

  // both stages move together whenever the output slot is free or draining
  logic adv;
  assign adv     = !m_valid || m_ready;
  assign s_ready = adv;

  logic [DATA_W-1:0]    px_in  [NCH];
  logic signed [IW-1:0] ch_off [NCH];
  logic signed [IW-1:0] ch_base[NCH];
  logic signed [IW-1:0] ch_pre [NCH];

  assign px_in[CH_Y]  = s_y;
  assign px_in[CH_CB] = s_cb;
  assign px_in[CH_CR] = s_cr;

  // brightness is two's complement; chroma offsets are centred on 128
  assign ch_off[CH_Y]  = {{(IW-CODE_W){cfg_q.bright[CODE_W-1]}}, cfg_q.bright};
  assign ch_off[CH_CB] = {{(IW-CODE_W){~cfg_q.cb_off[CODE_W-1]}},
                          ~cfg_q.cb_off[CODE_W-1], cfg_q.cb_off[CODE_W-2:0]};
  assign ch_off[CH_CR] = {{(IW-CODE_W){~cfg_q.cr_off[CODE_W-1]}},
                          ~cfg_q.cr_off[CODE_W-1], cfg_q.cr_off[CODE_W-2:0]};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    if (ch == CH_CR) begin : g_scaled
      yuv_pa_gain #(.DATA_W(DATA_W), .CODE_W(CODE_W), .IW(IW)) u_gain (
        .px   (px_in[ch]),
        .gain (cfg_q.cr_gain),
        .res  (ch_base[ch])
      );
    end else begin : g_plain
      assign ch_base[ch] = $signed({{(IW-DATA_W){1'b0}}, px_in[ch]});
    end
    assign ch_pre[ch] = ch_base[ch] + ch_off[ch];
  end

  // stage 1: unclamped sums
  logic                 st1_valid;
  logic signed [IW-1:0] st1_val [NCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st1_valid <= 1'b0;
      for (int i = 0; i < NCH; i++) st1_val[i] <= '0;
    end else if (adv) begin
      st1_valid <= s_valid;
      if (s_valid) begin
        for (int i = 0; i < NCH; i++) st1_val[i] <= ch_pre[i];
      end
    end
  end

  // stage 2: clamp and register output
  logic [DATA_W-1:0] sat_val [NCH];
  logic [DATA_W-1:0] out_q   [NCH];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_sat
    yuv_pa_sat #(.DATA_W(DATA_W), .IW(IW)) u_sat (
      .v (st1_val[ch]),
      .o (sat_val[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      for (int i = 0; i < NCH; i++) out_q[i] <= '0;
    end else if (adv) begin
      m_valid <= st1_valid;
      if (st1_valid) begin
        for (int i = 0; i < NCH; i++) out_q[i] <= sat_val[i];
      end
    end
  end

  assign m_y  = out_q[CH_Y];
  assign m_cb = out_q[CH_CB];
  assign m_cr = out_q[CH_CR];

endmodule

// File: rtl/yuv_pa_checker.sv
module yuv_pa_checker
  import yuv_pa_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [7:0]        cfg_wdata,
  input logic [7:0]        bright_q,
  input logic              st1_valid,
  input logic              s_ready,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_y,
  input logic [DATA_W-1:0] m_cb,
  input logic [DATA_W-1:0] m_cr
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !m_valid);

  assert_bright_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == ADDR_W'(ADDR_BRIGHT) |=> bright_q == $past(cfg_wdata));

  assert_two_stage_flow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st1_valid && (!m_valid || m_ready) |=> m_valid);

  assert_stall_blocks_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |-> !s_ready);

  assert_stall_holds_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_y) && $stable(m_cb) && $stable(m_cr));

endmodule

bind yuv_proc_amp yuv_pa_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pa_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .bright_q  (cfg_q.bright),
  .st1_valid (st1_valid),
  .s_ready   (s_ready),
  .m_valid   (m_valid),
  .m_ready   (m_ready),
  .m_y       (m_y),
  .m_cb      (m_cb),
  .m_cr      (m_cr)
);

// File: tb/test_yuv_proc_amp.sv
module test_yuv_proc_amp;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_y = '0, s_cb = '0, s_cr = '0;
  logic       m_valid;
  logic       m_ready = 1'b1;
  logic [7:0] m_y, m_cb, m_cr;

  always #(CLK_PERIOD/2) clk = ~clk;

  yuv_proc_amp i_yuv_proc_amp (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .s_valid(s_valid), .s_ready(s_ready), .s_y(s_y), .s_cb(s_cb), .s_cr(s_cr),
    .m_valid(m_valid), .m_ready(m_ready), .m_y(m_y), .m_cb(m_cb), .m_cr(m_cr)
  );

  int checks = 0;
  int errors = 0;
  int b_bri = 0, b_cbo = 128, b_cro = 128, b_gain = 128;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clamp8(int v);
    return (v < 0) ? 0 : ((v > 255) ? 255 : v);
  endfunction

  function automatic int exp_y(int y);
    return clamp8(y + ((b_bri > 127) ? b_bri - 256 : b_bri));
  endfunction
  function automatic int exp_cb(int cb);
    return clamp8(cb + b_cbo - 128);
  endfunction
  function automatic int exp_cr(int cr);
    int q;
    q = ((cr - 128) * b_gain) / 128;   // integer division truncates toward zero
    return clamp8(128 + q + b_cro - 128);
  endfunction

  task automatic cfg_write(int addr, int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'(addr); cfg_wdata = 8'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    case (addr)
      'h0A: b_bri  = data;
      'hE1: b_cbo  = data;
      'hE2: b_cro  = data;
      'hE4: b_gain = data;
      default: ;
    endcase
  endtask

  task automatic pix_check(string req, int y, int cb, int cr);
    @(negedge clk);
    s_valid = 1'b1; s_y = 8'(y); s_cb = 8'(cb); s_cr = 8'(cr);
    @(negedge clk);
    s_valid = 1'b0;
    check("R7", "m_valid one cycle after accept", int'(m_valid), 0);
    @(negedge clk);
    check(req, "m_valid", int'(m_valid), 1);
    check(req, "m_y",  int'(m_y),  exp_y(y));
    check(req, "m_cb", int'(m_cb), exp_cb(cb));
    check(req, "m_cr", int'(m_cr), exp_cr(cr));
  endtask

  task automatic restore_neutral();
    cfg_write('h0A, 'h00); cfg_write('hE1, 'h80);
    cfg_write('hE2, 'h80); cfg_write('hE4, 'h80);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "m_valid after reset", int'(m_valid), 0);
    check("R1", "s_ready after reset", int'(s_ready), 1);
    pix_check("R1", 17, 200, 99);
  endtask

  task automatic t_brightness();
    cfg_write('h0A, 'h10); pix_check("R3", 100, 30, 220);
    cfg_write('h0A, 'hF0); pix_check("R3", 100, 30, 220);
    cfg_write('h0A, 'h80); pix_check("R6", 50, 128, 128);
    cfg_write('h0A, 'h7F); pix_check("R6", 200, 128, 128);
    restore_neutral();
  endtask

  task automatic t_chroma_offset();
    cfg_write('hE1, 'h90); pix_check("R4", 60, 100, 100);
    cfg_write('hE2, 'h70); pix_check("R4", 60, 100, 100);
    cfg_write('hE1, 'h00); pix_check("R6", 60, 40, 100);
    cfg_write('hE1, 'hFF); pix_check("R6", 60, 240, 100);
    restore_neutral();
  endtask

  task automatic t_cr_gain();
    cfg_write('hE4, 'h00); pix_check("R5", 10, 10, 37);
    cfg_write('hE4, 'hFF); pix_check("R5", 10, 10, 200);
    pix_check("R6", 10, 10, 60);
    cfg_write('hE4, 'h40); pix_check("R5", 10, 10, 100);
    cfg_write('hE4, 'h41); pix_check("R5", 10, 10, 101);
    pix_check("R5", 10, 10, 155);
    cfg_write('hE2, 'h90); pix_check("R5", 10, 10, 155);
    restore_neutral();
  endtask

  task automatic t_bad_address();
    cfg_write('hE3, 'h00); cfg_write('h0B, 'h50);
    cfg_write('hE0, 'h00); cfg_write('h8A, 'h40);
    pix_check("R2", 77, 88, 99);
    check("R2", "cr unchanged after stray writes", int'(m_cr), 99);
    check("R2", "y unchanged after stray writes", int'(m_y), 77);
  endtask

  task automatic t_stream();
    int ys[3] = '{11, 22, 33};
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        check("R7", "streamed m_valid", int'(m_valid), 1);
        check("R7", "streamed m_y", int'(m_y), ys[k-2]);
      end
      if (k < 3) begin
        s_valid = 1'b1; s_y = 8'(ys[k]); s_cb = 8'd128; s_cr = 8'd128;
      end else s_valid = 1'b0;
    end
    @(negedge clk);
    check("R7", "m_valid after stream drains", int'(m_valid), 0);
  endtask

  task automatic t_backpressure();
    m_ready = 1'b0;
    @(negedge clk);
    s_valid = 1'b1; s_y = 8'd40; s_cb = 8'd50; s_cr = 8'd60;
    @(negedge clk);
    s_valid = 1'b0;
    @(negedge clk);
    check("R8", "m_valid while stalled", int'(m_valid), 1);
    check("R8", "s_ready while stalled", int'(s_ready), 0);
    s_valid = 1'b1; s_y = 8'd140; s_cb = 8'd150; s_cr = 8'd160;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8", "s_ready held low", int'(s_ready), 0);
      check("R8", "m_y held", int'(m_y), 40);
      check("R8", "m_cr held", int'(m_cr), 60);
    end
    m_ready = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    check("R8", "m_valid after drain", int'(m_valid), 0);
    @(negedge clk);
    check("R8", "blocked pixel delivered once", int'(m_valid), 1);
    check("R8", "blocked pixel m_y", int'(m_y), 140);
    check("R8", "blocked pixel m_cb", int'(m_cb), 150);
    @(negedge clk);
    check("R8", "no duplicate pixel", int'(m_valid), 0);
  endtask

  task automatic t_write_timing();
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'h0A; cfg_wdata = 8'h20;
    s_valid = 1'b1; s_y = 8'd100; s_cb = 8'd128; s_cr = 8'd128;
    @(negedge clk);
    cfg_we = 1'b0;
    s_y = 8'd101;
    @(negedge clk);
    s_valid = 1'b0;
    check("R9", "pixel on write edge uses old setting", int'(m_y), 100);
    @(negedge clk);
    check("R9", "next pixel uses new setting", int'(m_y), 133);
    b_bri = 'h20;
    restore_neutral();
  endtask

  initial begin
    t_reset();
    t_brightness();
    t_chroma_offset();
    t_cr_gain();
    t_bad_address();
    t_stream();
    t_backpressure();
    t_write_timing();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule